// File: doc/BRIEF.md
# MESI Coherence State Controller

This block keeps the coherence state of every line in a small private write-back cache that sits beside one other cache in a two-core system. The default geometry is 8 sets of 4 ways with 64-byte lines and 32-bit addresses. Each line holds a 2-bit state: Invalid, Shared, Exclusive or Modified. The block compares tags, picks replacement ways and carries out every state change.

Local loads and stores arrive on a request port and finish with a one-cycle done pulse. On a hit that needs no ownership, the pulse comes one cycle after acceptance. When the core needs a line or needs ownership of it, the block sends one message per transaction on an outgoing channel and waits for the matching reply from the endpoint. The endpoint is the other cache, memory, or both. For a read fill, the reply also says whether another cache kept a copy. Snoops from the other core arrive on their own port. Each snoop gets a registered response one cycle later. The response carries the state the line had before the snoop and a flag that says dirty data was supplied.

Top module: `coh_line_ctrl`

## Requirements
- R1: The address is decoded as bits [5:0] byte within line, bits [8:6] set index and bits [31:9] tag. Two addresses that differ only in the byte bits reach the same line. Every outgoing message carries a line address whose byte bits are zero.
- R2: A load miss sends exactly one read message (type 0) for its line. After the reply the line is Exclusive (code 2) if the reply's shared flag is low, and Shared (code 1) if it is high. State codes are Invalid 0, Shared 1, Exclusive 2, Modified 3.
- R3: A load hit in any valid state sends no message and completes with hit set. A store hit on a Modified line also sends no message. A store hit on an Exclusive line also sends no message and turns the line Modified.
- R4: A store to a Shared line, or a store that misses, sends one read-for-ownership message (type 1). The store completes only after that message's reply, and the line is then Modified. A store to a Shared line reports hit, and a store miss reports no hit.
- R5: When a miss fills a set that has an Invalid way, the lowest-numbered Invalid way is used, whatever the replacement pointer holds.
- R6: When every way of a set is valid, the victim is the way named by that set's own round-robin pointer. The pointer starts at way 0 and advances by one on each such eviction.
- R7: A Modified victim is first written back with a writeback message (type 2) carrying the victim's line address. The fill request is sent only after the writeback reply.
- R8: A snoop read (code 0) turns a Modified or Exclusive line Shared and leaves a Shared line Shared. The response flags supplied dirty data exactly when the line was Modified.
- R9: A snoop invalidate (code 1) or a snoop read-for-ownership (code 2) makes the line Invalid, and supplies dirty data if it was Modified. A later local access to that line misses and requests the line again.
- R10: A snoop to a line not present reports prior state Invalid and no dirty data, and changes nothing.
- R11: After reset every line is Invalid, the request port is ready and no message or done pulse is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local access present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Local access byte address |
| req_ready | output | 1 | Access accepted this cycle when req_valid is high |
| resp_done | output | 1 | One-cycle pulse when the access completes |
| resp_hit | output | 1 | Tag was present when the access was accepted (valid with resp_done) |
| msg_valid | output | 1 | One-cycle pulse for an outgoing message |
| msg_type | output | 2 | 0 read, 1 read-for-ownership, 2 writeback |
| msg_addr | output | 32 | Line address of the message |
| reply_valid | input | 1 | Reply to the outstanding message |
| reply_shared | input | 1 | With a read reply: another cache keeps a copy |
| snp_valid | input | 1 | Incoming snoop present |
| snp_type | input | 2 | 0 read, 1 invalidate, 2 read-for-ownership |
| snp_addr | input | 32 | Snooped byte address |
| snp_resp_valid | output | 1 | Snoop response, one cycle after the snoop |
| snp_resp_prev | output | 2 | Line state before the snoop |
| snp_resp_wb | output | 1 | Dirty data supplied by this cache |

## Verification
Each set is filled, upgraded, snooped and evicted in turn. The bench reads the line states back through snoop responses and checks the exact sequence of messages.

The replacement cases are the core of the test:
- Eviction with a full set checks that the pointer walks ways 0 to 3 for each set on its own. A design that shared one pointer, or never advanced it, would evict the wrong line.
- After a snoop invalidate, a refill must reuse the freed way while the pointer aims at a different line. A design that ignored Invalid ways would destroy a live line.

The ownership cases cover the remaining transitions:
- A Modified victim must produce a writeback before the fill. A design that skipped or reordered it would show a lone read or swapped messages.
- A store to an Exclusive line must send nothing. A store to a Shared line must send exactly one read-for-ownership.
- Snoops must downgrade Modified lines with dirty data and invalidate on read-for-ownership. A mistake here shows up as wrong prior states or a missing re-request.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {CS_I = 2'd0, CS_S = 2'd1, CS_E = 2'd2, CS_M = 2'd3} cstate_t;
  typedef enum logic [1:0] {MSG_READ = 2'd0, MSG_RFO = 2'd1, MSG_WB = 2'd2} msg_t;
  typedef enum logic [1:0] {SNP_READ = 2'd0, SNP_INV = 2'd1, SNP_RFO = 2'd2} snp_t;
  typedef enum logic [1:0] {L_IDLE = 2'd0, L_WB = 2'd1, L_FILL = 2'd2} lstate_t;
endpackage

// File: rtl/coh_tag_match.sv
module coh_tag_match #(
  parameter int TAG_W = 23,
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS*TAG_W-1:0] row_tags,
  input  logic [WAYS*2-1:0]     row_states,
  input  logic [TAG_W-1:0]      look_tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way,
  output logic [1:0]            hit_state
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = (row_states[w*2 +: 2] != 2'd0) &&
                      (row_tags[w*TAG_W +: TAG_W] == look_tag);
  end

  always_comb begin
    hit       = |match;
    hit_way   = '0;
    hit_state = 2'd0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit_way   = WAY_W'(w);
        hit_state = row_states[w*2 +: 2];
      end
    end
  end
endmodule

// File: rtl/coh_victim_pick.sv
module coh_victim_pick #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS*2-1:0] row_states,
  input  logic [WAY_W-1:0]  rr_ptr,
  output logic [WAY_W-1:0]  victim,
  output logic              all_valid
);
  // The lowest Invalid way wins; the round-robin pointer is used only when the set is full.
  always_comb begin
    victim    = rr_ptr;
    all_valid = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (row_states[w*2 +: 2] == 2'd0) begin
        victim    = WAY_W'(w);
        all_valid = 1'b0;
      end
    end
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 8,
  parameter int WAYS       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_done,
  output logic              resp_hit,
  output logic              msg_valid,
  output logic [1:0]        msg_type,
  output logic [ADDR_W-1:0] msg_addr,
  input  logic              reply_valid,
  input  logic              reply_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_type,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_resp_valid,
  output logic [1:0]        snp_resp_prev,
  output logic              snp_resp_wb
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [1:0]       st_q  [SETS][WAYS];
  logic [WAY_W-1:0] rr_q  [SETS];

  lstate_t          lst;
  logic [IDX_W-1:0] lk_set;
  logic [WAY_W-1:0] lk_way;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_write;

  logic [IDX_W-1:0] req_set, snp_set;
  logic [TAG_W-1:0] req_tag, snp_tag;
  logic [OFF_W*2-1:0] unused_offsets;
  assign req_set = req_addr[OFF_W +: IDX_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign snp_set = snp_addr[OFF_W +: IDX_W];
  assign snp_tag = snp_addr[ADDR_W-1 -: TAG_W];
  assign unused_offsets = {req_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};

  logic [WAYS*TAG_W-1:0] req_tags, snp_tags;
  logic [WAYS*2-1:0]     req_sts, snp_sts;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      req_tags[w*TAG_W +: TAG_W] = tag_q[req_set][w];
      req_sts[w*2 +: 2]          = st_q[req_set][w];
      snp_tags[w*TAG_W +: TAG_W] = tag_q[snp_set][w];
      snp_sts[w*2 +: 2]          = st_q[snp_set][w];
    end
  end

  logic             r_hit, s_hit, v_all;
  logic [WAY_W-1:0] r_way, s_way, v_way;
  logic [1:0]       r_st, s_st, v_st;

  coh_tag_match #(.TAG_W(TAG_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_req_match (
    .row_tags(req_tags), .row_states(req_sts), .look_tag(req_tag),
    .hit(r_hit), .hit_way(r_way), .hit_state(r_st));

  coh_tag_match #(.TAG_W(TAG_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_snp_match (
    .row_tags(snp_tags), .row_states(snp_sts), .look_tag(snp_tag),
    .hit(s_hit), .hit_way(s_way), .hit_state(s_st));

  coh_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .row_states(req_sts), .rr_ptr(rr_q[req_set]), .victim(v_way), .all_valid(v_all));

  assign v_st      = req_sts[v_way*2 +: 2];
  assign req_ready = (lst == L_IDLE) && !snp_valid;

  logic accept;
  assign accept = req_valid && req_ready;

  // Tag array: written only when a miss claims a way, no reset needed.
  always_ff @(posedge clk) begin
    if (!rst && accept && !r_hit) tag_q[req_set][v_way] <= req_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lst            <= L_IDLE;
      resp_done      <= 1'b0;
      resp_hit       <= 1'b0;
      msg_valid      <= 1'b0;
      msg_type       <= 2'd0;
      msg_addr       <= '0;
      snp_resp_valid <= 1'b0;
      snp_resp_prev  <= 2'd0;
      snp_resp_wb    <= 1'b0;
      lk_set         <= '0;
      lk_way         <= '0;
      lk_tag         <= '0;
      lk_write       <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) st_q[s][w] <= CS_I;
      end
    end else begin
      resp_done      <= 1'b0;
      msg_valid      <= 1'b0;
      snp_resp_valid <= 1'b0;

      if (snp_valid) begin
        snp_resp_valid <= 1'b1;
        snp_resp_prev  <= s_hit ? s_st : CS_I;
        snp_resp_wb    <= s_hit && (s_st == CS_M);
        if (s_hit) st_q[snp_set][s_way] <= (snp_type == SNP_READ) ? CS_S : CS_I;
      end

      case (lst)
        L_IDLE: if (accept) begin
          lk_set   <= req_set;
          lk_tag   <= req_tag;
          lk_write <= req_write;
          if (r_hit && (!req_write || r_st != CS_S)) begin
            resp_done <= 1'b1;
            resp_hit  <= 1'b1;
            if (req_write) st_q[req_set][r_way] <= CS_M;
          end else if (r_hit) begin
            lk_way    <= r_way;
            resp_hit  <= 1'b1;
            msg_valid <= 1'b1;
            msg_type  <= MSG_RFO;
            msg_addr  <= {req_tag, req_set, {OFF_W{1'b0}}};
            lst       <= L_FILL;
          end else begin
            lk_way    <= v_way;
            resp_hit  <= 1'b0;
            msg_valid <= 1'b1;
            st_q[req_set][v_way] <= CS_I;
            if (v_all) rr_q[req_set] <= rr_q[req_set] + 1'b1;
            if (v_st == CS_M) begin
              msg_type <= MSG_WB;
              msg_addr <= {tag_q[req_set][v_way], req_set, {OFF_W{1'b0}}};
              lst      <= L_WB;
            end else begin
              msg_type <= req_write ? MSG_RFO : MSG_READ;
              msg_addr <= {req_tag, req_set, {OFF_W{1'b0}}};
              lst      <= L_FILL;
            end
          end
        end
        L_WB: if (reply_valid) begin
          msg_valid <= 1'b1;
          msg_type  <= lk_write ? MSG_RFO : MSG_READ;
          msg_addr  <= {lk_tag, lk_set, {OFF_W{1'b0}}};
          lst       <= L_FILL;
        end
        L_FILL: if (reply_valid) begin
          st_q[lk_set][lk_way] <= lk_write ? CS_M : (reply_shared ? CS_S : CS_E);
          resp_done            <= 1'b1;
          lst                  <= L_IDLE;
        end
        default: lst <= L_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
  parameter int OFF_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             resp_done,
  input logic             resp_hit,
  input logic             msg_valid,
  input logic [OFF_W-1:0] msg_off,
  input logic             reply_valid,
  input logic             snp_valid,
  input logic             snp_resp_valid,
  input logic [1:0]       snp_resp_prev,
  input logic             snp_resp_wb
);
  assert_line_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_off == '0));

  assert_busy_while_msg_R4: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> !req_ready);

  assert_miss_after_reply_R2: assert property (@(posedge clk) disable iff (rst)
    (resp_done && !resp_hit) |-> $past(reply_valid));

  assert_snoop_answered_R8: assert property (@(posedge clk) disable iff (rst)
    snp_valid |=> snp_resp_valid);

  assert_dirty_only_modified_R8: assert property (@(posedge clk) disable iff (rst)
    (snp_resp_valid && snp_resp_wb) |-> (snp_resp_prev == 2'd3));

  assert_absent_clean_R10: assert property (@(posedge clk) disable iff (rst)
    (snp_resp_valid && snp_resp_prev == 2'd0) |-> !snp_resp_wb);
endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.OFF_W(OFF_W)) i_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .resp_done(resp_done),
  .resp_hit(resp_hit), .msg_valid(msg_valid), .msg_off(msg_addr[OFF_W-1:0]),
  .reply_valid(reply_valid), .snp_valid(snp_valid), .snp_resp_valid(snp_resp_valid),
  .snp_resp_prev(snp_resp_prev), .snp_resp_wb(snp_resp_wb));

// File: tb/test_coh_line_ctrl.sv
`timescale 1ns/1ps
module test_coh_line_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, resp_done, resp_hit;
  logic        msg_valid;
  logic [1:0]  msg_type;
  logic [31:0] msg_addr;
  logic        reply_valid = 1'b0, reply_shared = 1'b0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_type = '0;
  logic [31:0] snp_addr = '0;
  logic        snp_resp_valid, snp_resp_wb;
  logic [1:0]  snp_resp_prev;

  coh_line_ctrl i_coh_line_ctrl (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int mcnt = 0, rdly = 0;
  logic [1:0]  mty [8];
  logic [31:0] mad [8];
  bit rshared = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Message endpoint: logs each message and replies two cycles later.
  always @(negedge clk) begin
    if (reply_valid) reply_valid = 1'b0;
    if (msg_valid) begin
      if (mcnt < 8) begin
        mty[mcnt] = msg_type;
        mad[mcnt] = msg_addr;
      end
      mcnt++;
      rdly = 2;
    end else if (rdly == 1) begin
      reply_shared = rshared;
      reply_valid  = 1'b1;
      rdly = 0;
    end else if (rdly > 1) begin
      rdly--;
    end
  end

  function automatic logic [31:0] la(int tag, int set);
    return 32'((tag << 9) | (set << 6));
  endfunction

  task automatic access(bit w, logic [31:0] a, bit sh, output bit hit, output int nmsg);
    int t;
    mcnt = 0;
    rshared = sh;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!resp_done && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk("R4", "access completion timeout", t >= 200, 0);
    hit = resp_hit;
    nmsg = mcnt;
  endtask

  task automatic snoop(logic [1:0] ty, logic [31:0] a, output logic [1:0] prev, output bit wb);
    @(negedge clk);
    snp_valid = 1'b1; snp_type = ty; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R8", "snoop response valid", snp_resp_valid, 1);
    prev = snp_resp_prev;
    wb = snp_resp_wb;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit hit, wb;
    int n;
    logic [1:0] pv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", "ready after reset", req_ready, 1);
    chk("R11", "no message after reset", msg_valid, 0);
    chk("R11", "no done after reset", resp_done, 0);
    snoop(2'd0, la(100, 0), pv, wb);
    chk("R11", "line invalid after reset", pv, 0);
    chk("R10", "absent snoop no data", wb, 0);

    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 4; k++) begin
        access(0, la(100 + k, s) + 32'(k * 4), k == 3, hit, n);
        chk("R2", "fill miss", hit, 0);
        chk("R2", "fill message count", n, 1);
        chk("R2", "fill message type", mty[0], 0);
        chk("R1", "fill line address", mad[0], la(100 + k, s));
      end
      for (int k = 0; k < 4; k++) begin
        access(0, la(100 + k, s) + 32'(63 - k), 0, hit, n);
        chk("R1", "other byte hits same line", hit, 1);
        chk("R3", "load hit silent", n, 0);
      end
      access(1, la(100, s), 0, hit, n);
      chk("R3", "store to Exclusive hits", hit, 1);
      chk("R3", "store to Exclusive silent", n, 0);
      access(1, la(103, s), 0, hit, n);
      chk("R4", "upgrade reports hit", hit, 1);
      chk("R4", "upgrade message count", n, 1);
      chk("R4", "upgrade type", mty[0], 1);
      chk("R4", "upgrade address", mad[0], la(103, s));
      snoop(2'd0, la(100, s), pv, wb);
      chk("R3", "Exclusive store made Modified", pv, 3);
      chk("R8", "modified supplies data", wb, 1);
      snoop(2'd0, la(103, s), pv, wb);
      chk("R4", "upgrade made Modified", pv, 3);
      snoop(2'd0, la(101, s), pv, wb);
      chk("R2", "unshared fill Exclusive", pv, 2);
      chk("R8", "exclusive no data", wb, 0);
      snoop(2'd0, la(101, s), pv, wb);
      chk("R8", "snoop read leaves Shared", pv, 1);

      access(0, la(200, s), 0, hit, n);
      chk("R6", "evict way0 messages", n, 1);
      chk("R6", "clean victim read type", mty[0], 0);
      snoop(2'd0, la(100, s), pv, wb);
      chk("R6", "way0 line evicted", pv, 0);
      chk("R10", "absent snoop no data", wb, 0);
      access(0, la(201, s), 0, hit, n);
      snoop(2'd0, la(101, s), pv, wb);
      chk("R6", "pointer advanced to way1", pv, 0);
      access(1, la(102, s), 0, hit, n);
      chk("R3", "store Exclusive silent", n, 0);
      access(0, la(202, s), 0, hit, n);
      chk("R7", "dirty victim two messages", n, 2);
      chk("R7", "first is writeback", mty[0], 2);
      chk("R7", "writeback victim address", mad[0], la(102, s));
      chk("R7", "then read", mty[1], 0);
      chk("R7", "read new address", mad[1], la(202, s));
      access(1, la(203, s), 0, hit, n);
      chk("R4", "store miss no hit", hit, 0);
      chk("R4", "store miss one message", n, 1);
      chk("R4", "store miss rfo", mty[0], 1);
      snoop(2'd0, la(103, s), pv, wb);
      chk("R6", "way3 evicted", pv, 0);
      snoop(2'd0, la(203, s), pv, wb);
      chk("R4", "store miss Modified", pv, 3);

      snoop(2'd1, la(201, s), pv, wb);
      chk("R9", "invalidate prior Exclusive", pv, 2);
      access(0, la(201, s), 0, hit, n);
      chk("R9", "access after invalidate misses", hit, 0);
      chk("R9", "re-request count", n, 1);
      snoop(2'd0, la(200, s), pv, wb);
      chk("R5", "invalid way preferred over pointer", pv, 2);
      access(1, la(200, s), 0, hit, n);
      chk("R4", "shared store upgrade", mty[0], 1);
      snoop(2'd2, la(200, s), pv, wb);
      chk("R9", "rfo snoop prior Modified", pv, 3);
      chk("R9", "rfo snoop supplies data", wb, 1);
      access(0, la(200, s), 1, hit, n);
      chk("R9", "miss after rfo snoop", hit, 0);
      snoop(2'd1, la(200, s), pv, wb);
      chk("R2", "shared reply fills Shared", pv, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule